// File: doc/BRIEF.md
# Edge or Center Aligned PWM Wave Counter

This block is the timing engine of a multi-channel pulse-width modulator. A prescaler turns the system clock into a count tick. A wave counter then advances on that tick, in one of two ways. It either ramps up and wraps, which gives edge-aligned pulses, or it climbs to the top value and falls back, which gives center-aligned pulses. Each channel compares the count with its own compare value and drives one output pin. Each time the counter finishes a period, the block raises a one-cycle strobe. An upstream sample fetcher uses this strobe to pace the next values it supplies.

New compare values arrive on one load strobe, and the top value arrives on a separate input. Both are first held in staging and become active only at a period boundary. The top of the count comes from the configured value or, in waveform mode, from the value the sample fetcher supplies with the compare values. A load strobe, given while the block is enabled and idle, starts generation. A stop request finishes the period in progress and then halts. Dropping the enable halts at once.

Top module: `pwm_wave_counter`

## Requirements
- R1: After reset, and whenever the generator is idle, every bit of `pwm_o` is 0 and `period_end_o` stays 0. An active-low reset on `rst_ni` clears the outputs asynchronously.
- R2: With `center_i`=0 and active top T, the count steps 0,1,…,T and then wraps. A period therefore lasts T+1 ticks. Channel i is high for min(C,T+1) ticks of each period, where C is its compare value: the output is high while the count is below C.
- R3: With `center_i`=1 and active top T≥1, the count steps 0,1,…,T,T−1,…,1 and then returns to 0. A period lasts 2T ticks. A channel with compare C is high for 0 ticks when C=0, for 2C−1 ticks when 1≤C≤T, and for 2T ticks when C>T.
- R4: Prescaler code n (0 to 7) on `prescale_i` makes one count tick every 2^n clock cycles, so every period length is multiplied by 2^n.
- R5: `period_end_o` is a one-cycle pulse per completed period. It is high in the first clock cycle of the following period, when the count is back at 0.
- R6: When `wave_top_sel_i`=1, the top taken at a period boundary is the `sample_top_i` value captured with the last load, and `top_i` has no effect. When `wave_top_sel_i`=0, `top_i` is used.
- R7: Compare values loaded through `cmp_load_i`, and a changed `top_i`, have no effect on the outputs or on the period length until the next period boundary.
- R8: A one-cycle pulse on `stop_i` during a period leaves that period to run to its end. The generator halts at the boundary, with outputs low and no further `period_end_o`.
- R9: `enable_i`=0 halts generation from the next clock edge, and the outputs go low. A `cmp_load_i` pulse while `enable_i`=0 starts nothing.
- R10: A `cmp_load_i` pulse while enabled and idle starts generation at the next edge, with the count at 0 and the loaded values active immediately. With the prescaler at 1 and top T, edge mode, the first `period_end_o` comes T+1 cycles later.
- R11: `cmp_i` holds channel i in bits [14i+13:14i]. Output bit i of `pwm_o` belongs to channel i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Generator enable; 0 halts at once |
| center_i | input | 1 | 0 edge-aligned up count, 1 center-aligned up-down count |
| prescale_i | input | 3 | Tick divider code n, divide by 2^n |
| top_i | input | 14 | Configured top of the count |
| wave_top_sel_i | input | 1 | 1 takes the top from the loaded sample |
| sample_top_i | input | 14 | Top value supplied with a sample, staged on load |
| cmp_i | input | 56 | Four 14-bit compare values, channel 0 in the low bits |
| cmp_load_i | input | 1 | Stage compare and sample top; starts an idle generator |
| stop_i | input | 1 | Request a halt at the end of the current period |
| pwm_o | output | 4 | Channel outputs |
| period_end_o | output | 1 | One-cycle strobe per completed period |

## Verification
The bench first walks a table of compare values at and beyond the top, with a top of 0 and of 1, in both counting modes and at the slowest prescaler. It measures each period's length and each channel's high time. A design that turned the count around one tick late, or counted the top twice in up-down mode, would give high times off by one tick. Directed tests then load values and change the top in the middle of a period. A design that applied them at once would glitch the current period or shorten it. Further directed tests raise stop mid-period: halting too early would cut the period short, and ignoring the stop would keep the period strobe running. The last directed tests drop the enable and load while disabled, which exposes a generator that keeps running or can be started when it should not.

// File: rtl/pwm_wc_pkg.sv
package pwm_wc_pkg;
  localparam int unsigned DEF_CNT_W = 14;
  localparam int unsigned DEF_NUM_CH = 4;
  localparam int unsigned DEF_PRE_W = 3;

  typedef enum logic {
    CNT_EDGE   = 1'b0,
    CNT_CENTER = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/pwm_wc_prescaler.sv
module pwm_wc_prescaler
  import pwm_wc_pkg::*;
#(
  parameter int unsigned PRE_W = DEF_PRE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  // low sel_i bits of the divider must all be set for a tick
  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      mask[i] = (i < int'(sel_i));
    end
  end

  assign tick_o = run_i && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (!run_i) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  p_tick_needs_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !tick_o);

  p_div1_every_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && sel_i == '0) |-> tick_o);
endmodule

// File: rtl/pwm_wc_counter.sv
module pwm_wc_counter
  import pwm_wc_pkg::*;
#(
  parameter int unsigned W = DEF_CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         tick_i,
  input  cnt_mode_e    mode_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         boundary_o
);
  logic [W-1:0] cnt_q, cnt_nxt;
  logic         up_q, up_nxt;
  logic         wrap;

  always_comb begin
    up_nxt  = up_q;
    cnt_nxt = '0;
    if (mode_i == CNT_EDGE) begin
      cnt_nxt = (cnt_q >= top_i) ? '0 : cnt_q + 1'b1;
    end else if (up_q) begin
      if (cnt_q < top_i) begin
        cnt_nxt = cnt_q + 1'b1;
      end else begin
        cnt_nxt = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
        up_nxt  = 1'b0;
      end
    end else begin
      cnt_nxt = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    end
    // a period is complete when the next count would land on zero
    wrap = (cnt_nxt == '0);
  end

  assign boundary_o = tick_i && wrap;
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (restart_i) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (tick_i) begin
      if (wrap) begin
        cnt_q <= '0;
        up_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_nxt;
        up_q  <= up_nxt;
      end
    end
  end

  p_cnt_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |-> cnt_q <= top_i);

  p_hold_without_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_wc_channel.sv
module pwm_wc_channel
  import pwm_wc_pkg::*;
#(
  parameter int unsigned W = DEF_CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         load_i,
  input  logic [W-1:0] cmp_i,
  input  logic [W-1:0] cnt_i,
  output logic         pwm_o
);
  logic [W-1:0] cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
    end else if (load_i) begin
      cmp_q <= cmp_i;
    end
  end

  assign pwm_o = run_i && (cnt_i < cmp_q);

  p_cmp_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !$past(load_i)) |-> $stable(cmp_q));
endmodule

// File: rtl/pwm_wave_counter.sv
module pwm_wave_counter
  import pwm_wc_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned PRE_W  = DEF_PRE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    enable_i,
  input  logic                    center_i,
  input  logic [PRE_W-1:0]        prescale_i,
  input  logic [CNT_W-1:0]        top_i,
  input  logic                    wave_top_sel_i,
  input  logic [CNT_W-1:0]        sample_top_i,
  input  logic [NUM_CH*CNT_W-1:0] cmp_i,
  input  logic                    cmp_load_i,
  input  logic                    stop_i,
  output logic [NUM_CH-1:0]       pwm_o,
  output logic                    period_end_o
);
  localparam int unsigned CMP_BITS = NUM_CH * CNT_W;

  logic                run_q, stop_q, per_end_q;
  logic [CMP_BITS-1:0] stage_cmp_q, src_cmp;
  logic [CNT_W-1:0]    stage_top_q, src_top, top_q;
  logic [CNT_W-1:0]    cnt;
  logic                tick, boundary, start, apply;
  cnt_mode_e           mode;

  assign mode  = center_i ? CNT_CENTER : CNT_EDGE;
  assign start = enable_i && !run_q && cmp_load_i;
  assign apply = start || (run_q && boundary);

  // a load in the boundary cycle is taken directly, not one period late
  assign src_cmp = cmp_load_i ? cmp_i : stage_cmp_q;
  assign src_top = wave_top_sel_i ? (cmp_load_i ? sample_top_i : stage_top_q) : top_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_cmp_q <= '0;
      stage_top_q <= '0;
    end else if (cmp_load_i && enable_i) begin
      stage_cmp_q <= cmp_i;
      stage_top_q <= sample_top_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q <= '0;
    end else if (apply) begin
      top_q <= src_top;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
    end else if (!enable_i) begin
      run_q <= 1'b0;
    end else if (start) begin
      run_q <= 1'b1;
    end else if (run_q && boundary && stop_q) begin
      run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b0;
    end else if (!enable_i || !run_q) begin
      stop_q <= 1'b0;
    end else if (stop_i) begin
      stop_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_end_q <= 1'b0;
    end else begin
      per_end_q <= run_q && boundary;
    end
  end

  assign period_end_o = per_end_q;

  pwm_wc_prescaler #(
    .PRE_W(PRE_W)
  ) u_prescaler (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_q),
    .sel_i (prescale_i),
    .tick_o(tick)
  );

  pwm_wc_counter #(
    .W(CNT_W)
  ) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (!run_q),
    .tick_i    (tick),
    .mode_i    (mode),
    .top_i     (top_q),
    .cnt_o     (cnt),
    .boundary_o(boundary)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_wc_channel #(
      .W(CNT_W)
    ) u_channel (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (run_q),
      .load_i(apply),
      .cmp_i (src_cmp[g*CNT_W +: CNT_W]),
      .cnt_i (cnt),
      .pwm_o (pwm_o[g])
    );
  end

  p_idle_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (pwm_o == '0));

  p_end_at_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_end_q |-> (cnt == '0));

  p_stop_at_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && stop_q && boundary) |=> !run_q);

  p_stop_waits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && enable_i && !boundary) |=> run_q);

  p_disable_halts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !run_q);

  p_start_at_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (run_q && cnt == '0));
endmodule

// File: tb/pwm_wave_counter_tb.sv
module pwm_wave_counter_tb;
  localparam int W = 14;
  localparam int N = 4;

  typedef struct packed {
    logic        center;
    logic [2:0]  pre;
    logic [13:0] top;
    logic [13:0] c0, c1, c2, c3;
    logic [15:0] per;
    logic [15:0] h0, h1, h2, h3;
  } vec_t;

  // expected period and high times in clock cycles, from R2/R3/R4
  localparam vec_t VEC [7] = '{
    '{1'b0, 3'd0, 14'd3, 14'd0, 14'd1, 14'd2, 14'd4, 16'd4,   16'd0,   16'd1,   16'd2,  16'd4},
    '{1'b0, 3'd2, 14'd4, 14'd2, 14'd5, 14'd3, 14'd9, 16'd20,  16'd8,   16'd20,  16'd12, 16'd20},
    '{1'b1, 3'd0, 14'd4, 14'd0, 14'd1, 14'd3, 14'd4, 16'd8,   16'd0,   16'd1,   16'd5,  16'd7},
    '{1'b1, 3'd1, 14'd3, 14'd2, 14'd4, 14'd1, 14'd3, 16'd12,  16'd6,   16'd12,  16'd2,  16'd10},
    '{1'b0, 3'd7, 14'd1, 14'd1, 14'd2, 14'd0, 14'd1, 16'd256, 16'd128, 16'd256, 16'd0,  16'd128},
    '{1'b1, 3'd3, 14'd1, 14'd1, 14'd0, 14'd2, 14'd1, 16'd16,  16'd8,   16'd0,   16'd16, 16'd8},
    '{1'b0, 3'd0, 14'd0, 14'd0, 14'd1, 14'd5, 14'd1, 16'd1,   16'd0,   16'd1,   16'd1,  16'd1}
  };

  logic           clk = 1'b0;
  logic           rst_ni;
  logic           enable_i, center_i, wave_top_sel_i, cmp_load_i, stop_i;
  logic [2:0]     prescale_i;
  logic [W-1:0]   top_i, sample_top_i;
  logic [N*W-1:0] cmp_i;
  logic [N-1:0]   pwm_o;
  logic           period_end_o;

  int checks = 0;
  int errors = 0;
  int m_cyc;
  int m_hi [N];

  always #5 clk = ~clk;

  pwm_wave_counter u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .enable_i      (enable_i),
    .center_i      (center_i),
    .prescale_i    (prescale_i),
    .top_i         (top_i),
    .wave_top_sel_i(wave_top_sel_i),
    .sample_top_i  (sample_top_i),
    .cmp_i         (cmp_i),
    .cmp_load_i    (cmp_load_i),
    .stop_i        (stop_i),
    .pwm_o         (pwm_o),
    .period_end_o  (period_end_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cmp(input int c0, input int c1, input int c2, input int c3);
    cmp_i = {W'(c3), W'(c2), W'(c1), W'(c0)};
  endtask

  task automatic start_gen(input bit ctr, input int pre, input int top);
    enable_i   = 1'b1;
    center_i   = ctr;
    prescale_i = 3'(pre);
    top_i      = W'(top);
    cmp_load_i = 1'b1;
    step(1);
    cmp_load_i = 1'b0;
  endtask

  task automatic wait_pulse();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (period_end_o) break;
    end
  endtask

  // called at a negedge where period_end_o is high; measures one period
  task automatic measure_here();
    m_cyc = 0;
    for (int ch = 0; ch < N; ch++) m_hi[ch] = 0;
    do begin
      for (int ch = 0; ch < N; ch++) m_hi[ch] += int'(pwm_o[ch]);
      m_cyc++;
      @(negedge clk);
    end while (!period_end_o && m_cyc < 5000);
  endtask

  task automatic quiet_window(input int n, input string req);
    int act;
    act = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (period_end_o || pwm_o != '0) act++;
    end
    chk(act == 0, req, "active cycles while halted", act, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_ni = 1'b0; enable_i = 1'b0; center_i = 1'b0; wave_top_sel_i = 1'b0;
    cmp_load_i = 1'b0; stop_i = 1'b0; prescale_i = '0; top_i = '0;
    sample_top_i = '0; cmp_i = '0;
    step(3);
    chk(pwm_o == '0, "R1", "pwm in reset", int'(pwm_o), 0);
    chk(period_end_o == 1'b0, "R1", "period_end in reset", int'(period_end_o), 0);
    rst_ni = 1'b1;
    step(2);

    // R9: load while disabled starts nothing
    set_cmp(5, 5, 5, 5);
    top_i = W'(3);
    cmp_load_i = 1'b1;
    step(1);
    cmp_load_i = 1'b0;
    quiet_window(30, "R9");

    // table walk, R2 R3 R4 R11
    for (int v = 0; v < 7; v++) begin
      set_cmp(int'(VEC[v].c0), int'(VEC[v].c1), int'(VEC[v].c2), int'(VEC[v].c3));
      start_gen(VEC[v].center, int'(VEC[v].pre), int'(VEC[v].top));
      wait_pulse();
      measure_here();
      chk(m_cyc == int'(VEC[v].per), VEC[v].pre != 0 ? "R4" : (VEC[v].center ? "R3" : "R2"),
          "period cycles", m_cyc, int'(VEC[v].per));
      chk(m_hi[0] == int'(VEC[v].h0), VEC[v].center ? "R3" : "R2", "ch0 high", m_hi[0], int'(VEC[v].h0));
      chk(m_hi[1] == int'(VEC[v].h1), VEC[v].center ? "R3" : "R2", "ch1 high", m_hi[1], int'(VEC[v].h1));
      chk(m_hi[2] == int'(VEC[v].h2), "R11", "ch2 high", m_hi[2], int'(VEC[v].h2));
      chk(m_hi[3] == int'(VEC[v].h3), "R11", "ch3 high", m_hi[3], int'(VEC[v].h3));
      enable_i = 1'b0;
      step(2);
    end

    // R10: start with count 0, first strobe after T+1 cycles
    set_cmp(5, 5, 5, 5);
    start_gen(1'b0, 0, 9);
    chk(pwm_o == 4'hF, "R10", "pwm right after start", int'(pwm_o), 15);
    n = 0;
    while (!period_end_o && n < 100) begin step(1); n++; end
    chk(n == 10, "R10", "cycles to first period end", n, 10);
    chk(period_end_o == 1'b1, "R5", "strobe at period start", int'(period_end_o), 1);
    step(1);
    chk(period_end_o == 1'b0, "R5", "strobe one cycle wide", int'(period_end_o), 0);

    // R7: mid-period load and top change take effect at the boundary
    step(1);
    set_cmp(1, 1, 1, 1);
    top_i = W'(4);
    cmp_load_i = 1'b1;
    step(1);
    cmp_load_i = 1'b0;
    chk(pwm_o == 4'hF, "R7", "old compare kept mid period", int'(pwm_o), 15);
    n = 0;
    while (!period_end_o && n < 100) begin step(1); n++; end
    chk(n == 7, "R7", "old top kept for current period", n, 7);
    measure_here();
    chk(m_cyc == 5, "R7", "new top period", m_cyc, 5);
    chk(m_hi[0] == 1, "R7", "new compare high time", m_hi[0], 1);

    // R6: waveform top from sample, top_i ignored
    wave_top_sel_i = 1'b1;
    sample_top_i = W'(7);
    top_i = W'(2);
    set_cmp(3, 3, 3, 3);
    cmp_load_i = 1'b1;
    step(1);
    cmp_load_i = 1'b0;
    wait_pulse();
    measure_here();
    chk(m_cyc == 8, "R6", "period from sample top", m_cyc, 8);
    chk(m_hi[3] == 3, "R6", "high time with sample top", m_hi[3], 3);

    // R8: stop waits for the end of the period
    step(2);
    stop_i = 1'b1;
    step(1);
    stop_i = 1'b0;
    n = 0;
    while (!period_end_o && n < 100) begin step(1); n++; end
    chk(n == 5, "R8", "cycles from stop to final strobe", n, 5);
    chk(pwm_o == '0, "R8", "pwm after stop boundary", int'(pwm_o), 0);
    quiet_window(40, "R8");

    // R9: enable low halts at once
    wave_top_sel_i = 1'b0;
    set_cmp(30, 30, 30, 30);
    start_gen(1'b0, 0, 20);
    step(3);
    chk(pwm_o == 4'hF, "R9", "pwm before disable", int'(pwm_o), 15);
    enable_i = 1'b0;
    step(1);
    chk(pwm_o == '0, "R9", "pwm after disable", int'(pwm_o), 0);
    quiet_window(30, "R9");

    // R1: asynchronous reset mid-run
    start_gen(1'b1, 0, 20);
    step(2);
    rst_ni = 1'b0;
    #1;
    chk(pwm_o == '0, "R1", "pwm on async reset", int'(pwm_o), 0);
    step(2);
    rst_ni = 1'b1;
    step(2);
    chk(pwm_o == '0 && period_end_o == 1'b0, "R1", "idle after reset", int'(pwm_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule